// File: doc/BRIEF.md
# Per-Core Performance-State Sequencer

This block keeps a small table of operating points for every core of a multi-core processor model and moves each core between them on command. Each table entry carries a valid flag plus a packed word holding a frequency multiplier, a power-of-two divisor and a voltage code. A core asks for a new entry with a strobe. The block clamps the request against a ceiling and a thermal floor, then runs the change in a safe order. The voltage rail is shared by all cores. The core's clock code changes only after that rail can support it, and a programmable lock delay follows every clock change.

Outputs are codes only: the applied multiplier and divisor per core, the derived clock in MHz, each core's voltage demand, and the shared rail code. A regulator and a PLL outside the block act on these codes. Table entries are loaded through a write-only register port that is addressed by core and slot.

Top module: `pstc_ctrl`

## Requirements
- R1: After reset every core reports state 0, multiplier 10, divisor 0 (2600 MHz) and busy low, and the rail code is 18h. Slots 0 and 1 of each core are valid and slots 2 to 4 are invalid.
- R2: A register write stores a valid flag and a 32-bit word into one slot of one core. The word holds the multiplier in bits [5:0], the divisor code in bits [8:6] and the voltage code in bits [15:9].
- R3: The reported clock is 100 × (multiplier + 16) shifted right by the divisor code, in MHz. Multiplier 10 with divisor 0 gives 2600; multiplier 7 with divisor 1 gives 1150.
- R4: A command whose clamped target slot is invalid is dropped, and the core keeps its state and clock.
- R5: A commanded state number larger than the ceiling input is replaced by the ceiling.
- R6: The thermal floor is the larger of the hardware and software limit inputs, capped at the ceiling. A commanded state below the floor is raised to the floor.
- R7: A command for the state already active is dropped, even if that slot was rewritten meanwhile. The new contents apply once the core leaves that state and returns to it.
- R8: Busy is high from the cycle after a command is accepted until the transition completes. Commands that arrive while busy are dropped.
- R9: With the rail already adequate, a transition keeps busy high for exactly (lock select + 1) × LOCK_UNIT cycles. The state number changes together with a one-cycle done pulse, and only then.
- R10: When the new entry has a higher clock or a lower voltage code, the core's voltage demand is raised first. Its clock code changes only once the rail code is at or below that demand. Otherwise the clock code changes on acceptance, and the voltage demand is relaxed at completion.
- R11: The rail code settles to the lowest voltage code demanded across all cores, which is the highest voltage.
- R12: With step mode set, the rail code moves by at most one code per cycle toward its target. With step mode clear, it reaches the target in a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Slot write strobe |
| reg_core | input | CORE_W | Core addressed by the write |
| reg_slot | input | 3 | Slot addressed by the write |
| reg_valid | input | 1 | Valid flag written to the slot |
| reg_word | input | 32 | Operating-point word written to the slot |
| cmd_stb | input | NUM_CORES | Per-core command strobe |
| cmd_state | input | 3*NUM_CORES | Per-core requested state |
| max_state | input | 3 | Ceiling on state number (lowest performance allowed) |
| hw_limit | input | 3 | Hardware thermal floor |
| sw_limit | input | 3 | Software thermal floor |
| lock_sel | input | 3 | Lock delay select |
| vstep_mode | input | 1 | 1: step rail one code per cycle, 0: jump |
| cur_state | output | 3*NUM_CORES | Active state per core |
| core_fid | output | 6*NUM_CORES | Applied multiplier per core |
| core_did | output | 3*NUM_CORES | Applied divisor code per core |
| core_mhz | output | 14*NUM_CORES | Applied clock in MHz per core |
| core_vid | output | 7*NUM_CORES | Voltage demand per core |
| busy | output | NUM_CORES | Transition in progress per core |
| done | output | NUM_CORES | One-cycle completion pulse per core |
| vdd_code | output | 7 | Shared rail voltage code |

## Verification
The checker relies on reset being applied before the first command. It also relies on the step-mode input staying constant during a transition, and on slot words for an active state not being used as evidence of a reload. The bench changes the mode, the ceiling and the limit inputs only while every core is idle. It rewrites a slot only while that slot is active or unused, so each result follows from the requirements alone. The rail-ordering checks use two cores with different voltage codes. This places the shared rail both above and below the moving core's demand.

// File: rtl/pstc_pkg.sv
package pstc_pkg;
   localparam int FID_W = 6;
   localparam int DID_W = 3;
   localparam int VID_W = 7;
   localparam int MHZ_W = 14;
   localparam int ST_W  = 3;

   typedef struct packed {
      logic [VID_W-1:0] nbvid;
      logic [1:0]       rsv_hi;
      logic             nbdid;
      logic [5:0]       rsv_mid;
      logic [VID_W-1:0] vid;
      logic [DID_W-1:0] did;
      logic [FID_W-1:0] fid;
   } op_word_t;

   function automatic logic [MHZ_W-1:0] freq_mhz(input logic [FID_W-1:0] fid,
                                                 input logic [DID_W-1:0] did);
      logic [MHZ_W-1:0] base;
      base = MHZ_W'(100 * (int'(fid) + 16));
      return base >> did;
   endfunction
endpackage

// File: rtl/pstc_slot_bank.sv
module pstc_slot_bank
   import pstc_pkg::*;
#(
   parameter int          NUM_CORES   = 2,
   parameter int          NUM_PSTATES = 5,
   parameter int          CORE_W      = 1,
   parameter logic [31:0] P0_WORD     = 32'h3000_300A,
   parameter logic [31:0] P1_WORD     = 32'h3000_5047
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [CORE_W-1:0]         wr_core,
   input  logic [ST_W-1:0]           wr_slot,
   input  logic                      wr_valid,
   input  logic [31:0]               wr_word,
   input  logic [NUM_CORES*ST_W-1:0] rd_idx,
   output logic [NUM_CORES-1:0]      rd_valid,
   output logic [NUM_CORES*32-1:0]   rd_word
);
   logic        vld [NUM_CORES][NUM_PSTATES];
   logic [31:0] mem [NUM_CORES][NUM_PSTATES];

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      for (genvar s = 0; s < NUM_PSTATES; s++) begin : g_slot
         localparam logic [31:0] RST_W = (s == 0) ? P0_WORD : (s == 1) ? P1_WORD : 32'h0;
         localparam logic        RST_V = (s < 2);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld[c][s] <= RST_V;
               mem[c][s] <= RST_W;
            end else if (wr && (int'(wr_core) == c) && (int'(wr_slot) == s)) begin
               vld[c][s] <= wr_valid;
               mem[c][s] <= wr_word;
            end
         end
      end

      always_comb begin
         rd_valid[c]        = 1'b0;
         rd_word[c*32 +: 32] = '0;
         for (int s = 0; s < NUM_PSTATES; s++) begin
            if (int'(rd_idx[c*ST_W +: ST_W]) == s) begin
               rd_valid[c]         = vld[c][s];
               rd_word[c*32 +: 32] = mem[c][s];
            end
         end
      end
   end
endmodule

// File: rtl/pstc_core_seq.sv
module pstc_core_seq
   import pstc_pkg::*;
#(
   parameter int          LOCK_UNIT = 4,
   parameter int          CNT_W     = 8,
   parameter logic [31:0] RST_WORD  = 32'h3000_300A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_stb,
   input  logic [ST_W-1:0]  cmd_state,
   input  logic [ST_W-1:0]  max_state,
   input  logic [ST_W-1:0]  hw_limit,
   input  logic [ST_W-1:0]  sw_limit,
   input  logic [2:0]       lock_sel,
   input  logic             rd_valid,
   input  logic [31:0]      rd_word,
   input  logic [VID_W-1:0] vdd_code,
   output logic [ST_W-1:0]  rd_idx,
   output logic [ST_W-1:0]  cur_state,
   output logic [FID_W-1:0] fid,
   output logic [DID_W-1:0] did,
   output logic [MHZ_W-1:0] mhz,
   output logic [VID_W-1:0] vid,
   output logic             busy,
   output logic             done
);
   typedef enum logic [1:0] {S_IDLE, S_VWAIT, S_LOCK} seq_t;
   localparam op_word_t RST_OP = op_word_t'(RST_WORD);

   seq_t             st;
   logic [ST_W-1:0]  tgt_q;
   op_word_t         pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ST_W-1:0]  therm, floor_s, tgt_c;
   op_word_t         nw;
   logic [MHZ_W-1:0] new_mhz;
   logic             accept, raise;
   logic [CNT_W-1:0] lock_len;

   always_comb begin
      therm   = (hw_limit > sw_limit) ? hw_limit : sw_limit;
      floor_s = (therm > max_state) ? max_state : therm;
      tgt_c   = (cmd_state > max_state) ? max_state : cmd_state;
      if (tgt_c < floor_s) tgt_c = floor_s;
   end

   assign rd_idx   = tgt_c;
   assign nw       = op_word_t'(rd_word);
   assign new_mhz  = freq_mhz(nw.fid, nw.did);
   assign mhz      = freq_mhz(fid, did);
   assign raise    = (new_mhz > mhz) || (nw.vid < vid);
   assign accept   = cmd_stb && (st == S_IDLE) && rd_valid && (tgt_c != cur_state);
   assign lock_len = CNT_W'((int'(lock_sel) + 1) * LOCK_UNIT - 1);
   assign busy     = (st != S_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         tgt_q     <= '0;
         pend_q    <= RST_OP;
         cnt_q     <= '0;
         cur_state <= '0;
         fid       <= RST_OP.fid;
         did       <= RST_OP.did;
         vid       <= RST_OP.vid;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            S_IDLE: if (accept) begin
               tgt_q  <= tgt_c;
               pend_q <= nw;
               if (raise) begin
                  vid <= nw.vid;
                  st  <= S_VWAIT;
               end else begin
                  fid   <= nw.fid;
                  did   <= nw.did;
                  cnt_q <= lock_len;
                  st    <= S_LOCK;
               end
            end
            S_VWAIT: if (vdd_code <= vid) begin
               fid   <= pend_q.fid;
               did   <= pend_q.did;
               cnt_q <= lock_len;
               st    <= S_LOCK;
            end
            S_LOCK: if (cnt_q == '0) begin
               cur_state <= tgt_q;
               vid       <= pend_q.vid;
               done      <= 1'b1;
               st        <= S_IDLE;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pstc_vdd_plane.sv
module pstc_vdd_plane
   import pstc_pkg::*;
#(
   parameter int               NUM_CORES = 2,
   parameter logic [VID_W-1:0] RST_VID   = 7'h18
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       step_mode,
   input  logic [NUM_CORES*VID_W-1:0] demand,
   output logic [VID_W-1:0]           vdd
);
   logic [VID_W-1:0] target;

   always_comb begin
      target = demand[VID_W-1:0];
      for (int c = 1; c < NUM_CORES; c++)
         if (demand[c*VID_W +: VID_W] < target) target = demand[c*VID_W +: VID_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  vdd <= RST_VID;
      else if (!step_mode)         vdd <= target;
      else if (vdd > target)       vdd <= vdd - 1'b1;
      else if (vdd < target)       vdd <= vdd + 1'b1;
   end
endmodule

// File: rtl/pstc_ctrl.sv
module pstc_ctrl
   import pstc_pkg::*;
#(
   parameter int          NUM_CORES   = 2,
   parameter int          NUM_PSTATES = 5,
   parameter int          LOCK_UNIT   = 4,
   parameter int          CNT_W       = 8,
   parameter logic [31:0] P0_WORD     = 32'h3000_300A,
   parameter logic [31:0] P1_WORD     = 32'h3000_5047,
   localparam int         CORE_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic [CORE_W-1:0]           reg_core,
   input  logic [2:0]                  reg_slot,
   input  logic                        reg_valid,
   input  logic [31:0]                 reg_word,
   input  logic [NUM_CORES-1:0]        cmd_stb,
   input  logic [NUM_CORES*3-1:0]      cmd_state,
   input  logic [2:0]                  max_state,
   input  logic [2:0]                  hw_limit,
   input  logic [2:0]                  sw_limit,
   input  logic [2:0]                  lock_sel,
   input  logic                        vstep_mode,
   output logic [NUM_CORES*3-1:0]      cur_state,
   output logic [NUM_CORES*6-1:0]      core_fid,
   output logic [NUM_CORES*3-1:0]      core_did,
   output logic [NUM_CORES*14-1:0]     core_mhz,
   output logic [NUM_CORES*7-1:0]      core_vid,
   output logic [NUM_CORES-1:0]        busy,
   output logic [NUM_CORES-1:0]        done,
   output logic [6:0]                  vdd_code
);
   localparam op_word_t P0_OP = op_word_t'(P0_WORD);

   if (NUM_PSTATES < 2 || NUM_PSTATES > (1 << ST_W)) begin : g_bad_states
      $error("NUM_PSTATES must lie between 2 and 8");
   end
   if ((8 * LOCK_UNIT) > (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for the longest lock delay");
   end
   if (NUM_CORES < 1) begin : g_bad_cores
      $error("NUM_CORES must be at least 1");
   end

   logic [NUM_CORES*ST_W-1:0] rd_idx;
   logic [NUM_CORES-1:0]      rd_valid;
   logic [NUM_CORES*32-1:0]   rd_word;

   pstc_slot_bank #(
      .NUM_CORES(NUM_CORES), .NUM_PSTATES(NUM_PSTATES), .CORE_W(CORE_W),
      .P0_WORD(P0_WORD), .P1_WORD(P1_WORD)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wr_core(reg_core), .wr_slot(reg_slot),
      .wr_valid(reg_valid), .wr_word(reg_word), .rd_idx(rd_idx),
      .rd_valid(rd_valid), .rd_word(rd_word)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      pstc_core_seq #(
         .LOCK_UNIT(LOCK_UNIT), .CNT_W(CNT_W), .RST_WORD(P0_WORD)
      ) u_seq (
         .clk(clk), .rst_n(rst_n),
         .cmd_stb(cmd_stb[c]), .cmd_state(cmd_state[c*3 +: 3]),
         .max_state(max_state), .hw_limit(hw_limit), .sw_limit(sw_limit),
         .lock_sel(lock_sel), .rd_valid(rd_valid[c]), .rd_word(rd_word[c*32 +: 32]),
         .vdd_code(vdd_code), .rd_idx(rd_idx[c*ST_W +: ST_W]),
         .cur_state(cur_state[c*3 +: 3]), .fid(core_fid[c*6 +: 6]),
         .did(core_did[c*3 +: 3]), .mhz(core_mhz[c*14 +: 14]),
         .vid(core_vid[c*7 +: 7]), .busy(busy[c]), .done(done[c])
      );
   end

   pstc_vdd_plane #(.NUM_CORES(NUM_CORES), .RST_VID(P0_OP.vid)) u_vdd (
      .clk(clk), .rst_n(rst_n), .step_mode(vstep_mode),
      .demand(core_vid), .vdd(vdd_code)
   );
endmodule

// File: rtl/pstc_ctrl_chk.sv
module pstc_ctrl_chk #(
   parameter int NUM_CORES = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    vstep_mode,
   input logic [NUM_CORES*3-1:0]  cur_state,
   input logic [NUM_CORES*14-1:0] core_mhz,
   input logic [NUM_CORES*7-1:0]  core_vid,
   input logic [NUM_CORES-1:0]    busy,
   input logic [NUM_CORES-1:0]    done,
   input logic [6:0]              vdd_code
);
   // R12: stepping never moves the rail by more than one code per cycle
   a_r12_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (vstep_mode && $past(vstep_mode)) |->
         (vdd_code == $past(vdd_code) || vdd_code == $past(vdd_code) + 7'd1 ||
          $past(vdd_code) == vdd_code + 7'd1));

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
      // R10: a clock increase only happens once the rail covers the demand
      a_r10_volt_before_freq: assert property (@(posedge clk) disable iff (!rst_n)
         (core_mhz[c*14 +: 14] > $past(core_mhz[c*14 +: 14])) |->
            (vdd_code <= core_vid[c*7 +: 7]));
      // R11: an idle core always sees a rail at least as high as it asks for
      a_r11_idle_covered: assert property (@(posedge clk) disable iff (!rst_n)
         !busy[c] |-> (vdd_code <= core_vid[c*7 +: 7]));
      // R8: clock code is frozen while the core stays idle
      a_r8_freq_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (!busy[c] && !$past(busy[c])) |-> $stable(core_mhz[c*14 +: 14]));
      // R9: state number moves only with the completion pulse
      a_r9_state_with_done: assert property (@(posedge clk) disable iff (!rst_n)
         (cur_state[c*3 +: 3] != $past(cur_state[c*3 +: 3])) |-> done[c]);
      // R9: completion pulse is a single cycle
      a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
         done[c] |=> !done[c]);
   end
endmodule

bind pstc_ctrl pstc_ctrl_chk #(.NUM_CORES(NUM_CORES)) u_pstc_chk (
   .clk(clk), .rst_n(rst_n), .vstep_mode(vstep_mode), .cur_state(cur_state),
   .core_mhz(core_mhz), .core_vid(core_vid), .busy(busy), .done(done),
   .vdd_code(vdd_code)
);

// File: tb/pstc_ctrl_test.sv
module pstc_ctrl_test;
   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [0:0]    reg_core = '0;
   logic [2:0]    reg_slot = '0;
   logic          reg_valid = 1'b0;
   logic [31:0]   reg_word = '0;
   logic [NC-1:0] cmd_stb = '0;
   logic [NC*3-1:0] cmd_state = '0;
   logic [2:0]    max_state = 3'd4, hw_limit = 3'd0, sw_limit = 3'd0, lock_sel = 3'd2;
   logic          vstep_mode = 1'b0;
   logic [NC*3-1:0]  cur_state;
   logic [NC*6-1:0]  core_fid;
   logic [NC*3-1:0]  core_did;
   logic [NC*14-1:0] core_mhz;
   logic [NC*7-1:0]  core_vid;
   logic [NC-1:0]    busy, done;
   logic [6:0]       vdd_code;

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   pstc_ctrl #(.NUM_CORES(NC)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_core(reg_core), .reg_slot(reg_slot),
      .reg_valid(reg_valid), .reg_word(reg_word), .cmd_stb(cmd_stb), .cmd_state(cmd_state),
      .max_state(max_state), .hw_limit(hw_limit), .sw_limit(sw_limit), .lock_sel(lock_sel),
      .vstep_mode(vstep_mode), .cur_state(cur_state), .core_fid(core_fid),
      .core_did(core_did), .core_mhz(core_mhz), .core_vid(core_vid), .busy(busy),
      .done(done), .vdd_code(vdd_code)
   );

   typedef struct packed {
      logic [2:0]  cmd, mx, hw, sw, es;
      logic [13:0] em;
   } vec_t;

   // R3 R4 R5 R6: core 0 walk; slots 0..3 valid, slot 4 invalid
   localparam vec_t VEC [11] = '{
      '{3'd1, 3'd4, 3'd0, 3'd0, 3'd1, 14'd1150},  // R3 divisor 1
      '{3'd2, 3'd4, 3'd0, 3'd0, 3'd2, 14'd2000},
      '{3'd3, 3'd4, 3'd0, 3'd0, 3'd3, 14'd800},
      '{3'd0, 3'd4, 3'd0, 3'd0, 3'd0, 14'd2600},  // R3 divisor 0
      '{3'd4, 3'd4, 3'd0, 3'd0, 3'd0, 14'd2600},  // R4 invalid slot
      '{3'd7, 3'd3, 3'd0, 3'd0, 3'd3, 14'd800},   // R5 ceiling
      '{3'd0, 3'd4, 3'd2, 3'd1, 3'd2, 14'd2000},  // R6 hardware floor
      '{3'd1, 3'd4, 3'd0, 3'd3, 3'd3, 14'd800},   // R6 software floor
      '{3'd6, 3'd2, 3'd0, 3'd0, 3'd2, 14'd2000},  // R5 ceiling
      '{3'd0, 3'd1, 3'd3, 3'd0, 3'd1, 14'd1150},  // R6 floor capped by ceiling
      '{3'd0, 3'd4, 3'd0, 3'd0, 3'd0, 14'd2600}
   };

   function automatic int st_of(int c);  return int'(cur_state[c*3 +: 3]); endfunction
   function automatic int mhz_of(int c); return int'(core_mhz[c*14 +: 14]); endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      check(act == exp, tag, act, exp);
   endtask

   task automatic write_slot(input int c, input int s, input bit v, input logic [31:0] w);
      @(negedge clk);
      reg_wr = 1'b1; reg_core = 1'(c); reg_slot = 3'(s); reg_valid = v; reg_word = w;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic issue(input int c, input int s);
      @(negedge clk);
      cmd_stb[c] = 1'b1; cmd_state[c*3 +: 3] = 3'(s);
      @(negedge clk);
      cmd_stb[c] = 1'b0;
   endtask

   task automatic wait_idle(input int c);
      int n = 0;
      repeat (2) @(negedge clk);
      while (busy[c] && n < 500) begin @(negedge clk); n++; end
      check(n < 500, "R8 transition never completed", n, 500);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cnt, changes, prev, vd_at;
      bit seen, big;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_eq("R1 reset state core0", st_of(0), 0);
      chk_eq("R1 reset state core1", st_of(1), 0);
      chk_eq("R1 reset mhz core0", mhz_of(0), 2600);
      chk_eq("R1 reset rail", int'(vdd_code), 'h18);
      chk_eq("R1 reset busy", int'(busy), 0);

      // R2 slot programming: vid [15:9], did [8:6], fid [5:0]
      write_slot(0, 2, 1'b1, 32'h3000_4004);   // fid 4 did 0 vid 20h: 2000
      write_slot(0, 3, 1'b1, 32'h3000_6040);   // fid 0 did 1 vid 30h: 800

      foreach (VEC[i]) begin
         max_state = VEC[i].mx; hw_limit = VEC[i].hw; sw_limit = VEC[i].sw;
         issue(0, int'(VEC[i].cmd));
         wait_idle(0);
         chk_eq($sformatf("R2 R4 R5 R6 state vec %0d", i), st_of(0), int'(VEC[i].es));
         chk_eq($sformatf("R3 mhz vec %0d", i), mhz_of(0), int'(VEC[i].em));
      end
      chk_eq("R2 fid field", int'(core_fid[5:0]), 10);

      // R7 rewrite active slot 0 (fid 12: 2800), re-command same state
      write_slot(0, 0, 1'b1, 32'h3000_300C);
      issue(0, 0);
      chk_eq("R7 same state no busy", int'(busy[0]), 0);
      wait_idle(0);
      chk_eq("R7 same state no reload", mhz_of(0), 2600);
      issue(0, 1); wait_idle(0);
      issue(0, 0); wait_idle(0);
      chk_eq("R7 reload after leaving", mhz_of(0), 2800);

      // R9 down path, rail adequate: busy for (2+1)*4 = 12 cycles
      lock_sel = 3'd2;
      issue(0, 1);
      cnt = 0; seen = 1'b0;
      while (busy[0] && cnt < 100) begin
         cnt++;
         @(negedge clk);
         if (done[0]) seen = 1'b1;
      end
      chk_eq("R9 lock cycles", cnt, 12);
      chk_eq("R9 done pulse seen", int'(seen), 1);
      chk_eq("R9 state updated", st_of(0), 1);

      // R8 second command while busy is dropped
      issue(0, 3);
      issue(0, 2);
      wait_idle(0);
      chk_eq("R8 busy command dropped", st_of(0), 3);

      // R11 shared rail: core0 30h, core1 18h -> 18h; core1 to 28h -> 28h
      chk_eq("R11 rail follows highest demand", int'(vdd_code), 'h18);
      issue(1, 1); wait_idle(1);
      chk_eq("R11 rail after core1 relaxes", int'(vdd_code), 'h28);

      // R10 R12 up path in step mode: rail 28h -> 18h before clock rises
      vstep_mode = 1'b1;
      issue(0, 0);
      prev = int'(vdd_code); changes = 0; seen = 1'b0; big = 1'b0; vd_at = 0;
      repeat (60) begin
         @(negedge clk);
         if (int'(vdd_code) != prev) changes++;
         if (int'(vdd_code) - prev > 1 || prev - int'(vdd_code) > 1) big = 1'b1;
         if (!seen && mhz_of(0) != 800) begin seen = 1'b1; vd_at = int'(vdd_code); end
         prev = int'(vdd_code);
      end
      chk_eq("R12 step count", changes, 16);
      chk_eq("R12 no jump", int'(big), 0);
      check(seen && vd_at <= 'h18, "R10 rail before clock", vd_at, 'h18);
      chk_eq("R10 up path final mhz", mhz_of(0), 2800);

      // R10 down path: clock drops first while rail still high
      issue(0, 3);
      chk_eq("R10 down clock first", mhz_of(0), 800);
      chk_eq("R10 down rail unchanged", int'(vdd_code), 'h18);
      repeat (40) @(negedge clk);
      chk_eq("R10 R11 rail relaxed after down", int'(vdd_code), 'h28);

      // R12 jump mode: core1 to 18h in one change
      vstep_mode = 1'b0;
      issue(1, 0);
      prev = int'(vdd_code); changes = 0;
      repeat (40) begin
         @(negedge clk);
         if (int'(vdd_code) != prev) changes++;
         prev = int'(vdd_code);
      end
      chk_eq("R12 jump single change", changes, 1);
      chk_eq("R12 jump target", int'(vdd_code), 'h18);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule